// File: doc/BRIEF.md
# Synchronous SRAM Cycle Decoder

This block sits behind the control pins of a pipelined synchronous SRAM port. On every rising clock edge that is not stalled, it reads three chip enables, a load/advance pin, a write enable and the byte write selects. From these it decides what kind of cycle the edge starts: a deselect, a read, or a write. It also decides whether the edge begins a new burst or continues the one already running. The decision is registered. The array read and write strobes and the per-byte write mask come straight from that registered decision.

The data-bus output enable is handled apart from the clock. The bus is driven only while the registered cycle is a read and the asynchronous output enable is low, and it follows that pin at once. During a write the output enable is masked, so the bus stays tri-stated. A read with the output enable inactive is reported as a dummy read. A high clock enable turns the edge into a wait state: every register keeps its value. The memory array and the burst address counter live in other blocks.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: An edge with clock enable low, load/advance low (`burst_adv`=0) and any chip enable inactive (`en_a_n`=1, `en_b`=0 or `en_c_n`=1) gives cycle type DESEL (code 0), with both array strobes low and an all-zero byte mask.
- R2: An edge with `burst_adv`=1 keeps the previous operation. After a deselect the cycle stays DESEL with `burst_cont`=0. After a read it reads again with `burst_cont`=1. After a write it writes again with `burst_cont`=1.
- R3: An edge with all enables active, `burst_adv`=0 and `wr_n`=1 starts a read: `arr_rd`=1, `burst_cont`=0, and the cycle type is READ (code 1) while `out_en_n`=0.
- R4: An edge with all enables active, `burst_adv`=0, `wr_n`=0 and at least one `bwe_n` bit low starts a write: cycle type WRITE (code 3) and `arr_wr`=1. If every `bwe_n` bit is high, the edge decodes as DESEL.
- R5: On every write beat, whether it begins or continues a burst, `arr_byte_en` bit i is the inverse of `bwe_n` bit i as sampled on that beat's edge. Bit i controls byte i.
- R6: While the registered operation is a read and `out_en_n`=1, the cycle type is DUMMY (code 2), `dq_drive`=0 and `arr_rd` stays 1.
- R7: During a read, `dq_drive` follows `out_en_n` combinationally, with no clock edge needed.
- R8: During a write, `dq_drive` is 0 whatever the value of `out_en_n`.
- R9: An edge with `clk_en_n`=1 is a wait state. The stored operation, continue flag and mask hold. The cycle type is WAIT (code 4) and both strobes and the mask read as zero. The next enabled edge carries on from the held state.
- R10: After reset, the cycle type is DESEL, the strobes and mask are zero, and `dq_drive` is 0 even with `out_en_n`=0.
- R11: On a continue edge (`burst_adv`=1), the chip enables and `wr_n` have no effect on the resulting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_a_n | input | 1 | First chip enable, active low |
| en_b | input | 1 | Second chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| burst_adv | input | 1 | 0 = load a new cycle, 1 = continue the burst |
| wr_n | input | 1 | Write enable, active low |
| bwe_n | input | NBYTES | Byte write selects, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 inserts a wait state |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| cycle_type | output | 3 | 0 DESEL, 1 READ, 2 DUMMY, 3 WRITE, 4 WAIT |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe |
| arr_byte_en | output | NBYTES | Per-byte write mask, active high |
| burst_cont | output | 1 | Current active cycle continues a burst |
| dq_drive | output | 1 | Data bus output driver enable |

## Verification
The bench builds the block with NBYTES=2. With that width, every combination of the byte write selects, including the all-high write abort, can be swept on both begin and continue beats within a few cycles. Each row of the operation table is driven in turn. Wait states are placed in the middle of read and write bursts, and the output enable is toggled between edges to show that the bus drive reacts without a clock.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        CYC_DESEL = 3'd0,
        CYC_READ  = 3'd1,
        CYC_DUMMY = 3'd2,
        CYC_WRITE = 3'd3,
        CYC_WAIT  = 3'd4
    } cyc_e;

    typedef struct packed {
        op_e  op;
        logic cont;
    } cyc_state_t;

    localparam cyc_state_t STATE_RESET = '{op: OP_IDLE, cont: 1'b0};

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

endpackage

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  cyc_state_t        cur,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              burst_adv,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] bwe_n,
    output cyc_state_t        nxt,
    output logic [NBYTES-1:0] nxt_mask
);
    logic any_byte;
    logic sel;

    assign any_byte = |(~bwe_n);
    assign sel      = chip_selected(en_a_n, en_b, en_c_n);

    always_comb begin
        nxt      = cur;
        nxt_mask = '0;
        if (burst_adv) begin
            nxt.cont = (cur.op != OP_IDLE);
            if (cur.op == OP_WR) nxt_mask = ~bwe_n;
        end else begin
            nxt.cont = 1'b0;
            if (!sel)          nxt.op = OP_IDLE;
            else if (wr_n)     nxt.op = OP_RD;
            else if (any_byte) nxt.op = OP_WR;
            else               nxt.op = OP_IDLE;
            if (nxt.op == OP_WR) nxt_mask = ~bwe_n;
        end
    end
endmodule

// File: rtl/sram_cyc_state.sv
module sram_cyc_state
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              burst_adv,
    input  cyc_state_t        nxt,
    input  logic [NBYTES-1:0] nxt_mask,
    output cyc_state_t        cur,
    output logic [NBYTES-1:0] cur_mask,
    output logic              stalled
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= STATE_RESET;
            cur_mask <= '0;
            stalled  <= 1'b0;
        end else if (!clk_en_n) begin
            cur      <= nxt;
            cur_mask <= nxt_mask;
            stalled  <= 1'b0;
        end else begin
            stalled  <= 1'b1;
        end
    end

    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> (stalled && $stable(cur) && $stable(cur_mask)));

    assert_continue_keeps_op_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && burst_adv) |=> (cur.op == $past(cur.op)));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (cur.op == OP_IDLE && !stalled && cur_mask == '0));
endmodule

// File: rtl/sram_cyc_busctl.sv
module sram_cyc_busctl
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  cyc_state_t        cur,
    input  logic [NBYTES-1:0] cur_mask,
    input  logic              stalled,
    input  logic              out_en_n,
    output cyc_e              cyc,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic [NBYTES-1:0] arr_byte_en,
    output logic              burst_cont,
    output logic              dq_drive
);
    always_comb begin
        if (stalled) begin
            cyc = CYC_WAIT;
        end else begin
            unique case (cur.op)
                OP_RD:   cyc = out_en_n ? CYC_DUMMY : CYC_READ;
                OP_WR:   cyc = CYC_WRITE;
                default: cyc = CYC_DESEL;
            endcase
        end
    end

    assign arr_rd      = (cur.op == OP_RD) && !stalled;
    assign arr_wr      = (cur.op == OP_WR) && !stalled;
    assign arr_byte_en = arr_wr ? cur_mask : '0;
    assign burst_cont  = cur.cont && !stalled;
    assign dq_drive    = (cur.op == OP_RD) && !out_en_n;

    always_comb begin
        if (cur.op == OP_WR) begin
            assert_write_no_drive_R8: assert (!dq_drive);
        end
        if (cur.op == OP_RD && out_en_n && !stalled) begin
            assert_dummy_read_R6: assert (cyc == CYC_DUMMY && !dq_drive && arr_rd);
        end
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_cyc_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              burst_adv,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] bwe_n,
    input  logic              clk_en_n,
    input  logic              out_en_n,
    output logic [2:0]        cycle_type,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic [NBYTES-1:0] arr_byte_en,
    output logic              burst_cont,
    output logic              dq_drive
);
    cyc_state_t        cur, nxt;
    logic [NBYTES-1:0] cur_mask, nxt_mask;
    logic              stalled;
    cyc_e              cyc;

    sram_cyc_decode #(.NBYTES(NBYTES)) u_decode (
        .cur(cur), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_adv(burst_adv), .wr_n(wr_n), .bwe_n(bwe_n),
        .nxt(nxt), .nxt_mask(nxt_mask)
    );

    sram_cyc_state #(.NBYTES(NBYTES)) u_state (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .burst_adv(burst_adv),
        .nxt(nxt), .nxt_mask(nxt_mask),
        .cur(cur), .cur_mask(cur_mask), .stalled(stalled)
    );

    sram_cyc_busctl #(.NBYTES(NBYTES)) u_bus (
        .cur(cur), .cur_mask(cur_mask), .stalled(stalled), .out_en_n(out_en_n),
        .cyc(cyc), .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_byte_en(arr_byte_en),
        .burst_cont(burst_cont), .dq_drive(dq_drive)
    );

    assign cycle_type = cyc;

    assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && (en_a_n || !en_b || en_c_n))
        |=> (!arr_rd && !arr_wr && arr_byte_en == '0));

    assert_abort_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && !en_a_n && en_b && !en_c_n && !wr_n && (&bwe_n))
        |=> !arr_wr);

    assert_begin_read_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && !en_a_n && en_b && !en_c_n && wr_n)
        |=> (arr_rd && !burst_cont));

    assert_write_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && !en_a_n && en_b && !en_c_n && !wr_n && !(&bwe_n))
        |=> (arr_byte_en == ~$past(bwe_n)));
endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
    logic burst_adv = 1'b0, wr_n = 1'b1, clk_en_n = 1'b0, out_en_n = 1'b0;
    logic [NB-1:0] bwe_n = '1;
    logic [2:0]    cycle_type;
    logic          arr_rd, arr_wr, burst_cont, dq_drive;
    logic [NB-1:0] arr_byte_en;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference state: 0 idle, 1 read, 2 write
    int m_op = 0;
    bit m_stall = 0, m_cont = 0;
    logic [NB-1:0] m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_cycle_ctrl #(.NBYTES(NB)) uut (
        .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_adv(burst_adv), .wr_n(wr_n), .bwe_n(bwe_n), .clk_en_n(clk_en_n),
        .out_en_n(out_en_n), .cycle_type(cycle_type), .arr_rd(arr_rd),
        .arr_wr(arr_wr), .arr_byte_en(arr_byte_en), .burst_cont(burst_cont),
        .dq_drive(dq_drive)
    );

    task automatic model_edge();
        if (rst) begin
            m_op = 0; m_stall = 0; m_cont = 0; m_mask = '0;
        end else if (clk_en_n) begin
            m_stall = 1;
        end else begin
            m_stall = 0;
            if (burst_adv) begin
                m_cont = (m_op != 0);
            end else begin
                m_cont = 0;
                if (en_a_n || !en_b || en_c_n) m_op = 0;
                else if (wr_n)                 m_op = 1;
                else if (bwe_n != '1)          m_op = 2;
                else                           m_op = 0;
            end
            m_mask = (m_op == 2) ? ~bwe_n : '0;
        end
    endtask

    task automatic compare(input string req);
        int e_cyc;
        logic e_rd, e_wr, e_cont, e_drv;
        logic [NB-1:0] e_mask;
        if (m_stall)      e_cyc = 4;
        else if (m_op==1) e_cyc = out_en_n ? 2 : 1;
        else if (m_op==2) e_cyc = 3;
        else              e_cyc = 0;
        e_rd   = (m_op == 1) && !m_stall;
        e_wr   = (m_op == 2) && !m_stall;
        e_mask = e_wr ? m_mask : '0;
        e_cont = m_cont && !m_stall;
        e_drv  = (m_op == 1) && !out_en_n;
        vectors++;
        if (cycle_type !== 3'(e_cyc) || arr_rd !== e_rd || arr_wr !== e_wr ||
            arr_byte_en !== e_mask || burst_cont !== e_cont || dq_drive !== e_drv) begin
            errors++;
            $display("FAIL %s: got cyc=%0d rd=%b wr=%b mask=%b cont=%b drv=%b, expected cyc=%0d rd=%b wr=%b mask=%b cont=%b drv=%b",
                     req, cycle_type, arr_rd, arr_wr, arr_byte_en, burst_cont, dq_drive,
                     e_cyc, e_rd, e_wr, e_mask, e_cont, e_drv);
        end
    endtask

    task automatic step(input logic a_n, input logic b, input logic c_n, input logic adv,
                        input logic w_n, input logic [NB-1:0] bw, input logic ce_n,
                        input logic oe_n, input string req);
        en_a_n = a_n; en_b = b; en_c_n = c_n; burst_adv = adv; wr_n = w_n;
        bwe_n = bw; clk_en_n = ce_n; out_en_n = oe_n;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset with output enable active
        rst = 1'b1;
        step(1,0,1,0,1,'1,0,0,"R10");
        step(0,1,0,0,1,'1,0,0,"R10");
        rst = 1'b0;
        compare("R10");

        // R1: each chip enable inactive alone
        step(1,1,0,0,1,'1,0,0,"R1");
        step(0,0,0,0,1,'1,0,0,"R1");
        step(0,1,1,0,0,2'b00,0,0,"R1");
        // R2: continue after deselect stays idle
        step(0,1,0,1,1,'1,0,0,"R2");

        // R3: begin read, then continue with enables off (R11)
        step(0,1,0,0,1,'1,0,0,"R3");
        step(1,0,1,1,0,2'b00,0,0,"R11");
        step(0,1,0,1,1,'1,0,0,"R2");
        // R7: async output enable inside a read
        out_en_n = 1'b1; #1; compare("R7");
        out_en_n = 1'b0; #1; compare("R7");
        // R6: dummy read
        step(0,1,0,0,1,'1,0,1,"R6");
        step(0,1,0,1,1,'1,0,1,"R6");
        // R9: wait state during read burst, then resume
        step(0,1,0,0,0,2'b00,1,0,"R9");
        step(1,1,1,1,0,2'b00,1,0,"R9");
        step(0,1,0,1,1,'1,0,0,"R9");

        // R4: begin write, R5 mask each beat, all patterns
        for (int p = 0; p < 3; p++) begin
            step(0,1,0,0,0,NB'(p),0,0,"R4");
            for (int q = 0; q < 4; q++) step(0,1,0,1,1,NB'(q),0,0,"R5");
        end
        // R8: write never drives with oe active or inactive
        step(0,1,0,0,0,2'b10,0,0,"R8");
        out_en_n = 1'b1; #1; compare("R8");
        out_en_n = 1'b0; #1; compare("R8");
        // R11: continue write with chip disabled and wr_n high
        step(1,0,1,1,1,2'b01,0,0,"R11");
        // R9: wait inside write burst holds mask, then resume
        step(0,1,0,1,1,2'b00,1,0,"R9");
        step(0,1,0,1,1,2'b10,0,0,"R9");
        // R4: write abort with all selects high
        step(0,1,0,0,0,'1,0,0,"R4");
        step(0,1,0,1,0,2'b00,0,0,"R2");

        // mixed sequence
        step(0,1,0,0,1,'1,0,1,"R6");
        step(0,1,0,0,0,2'b01,0,0,"R4");
        step(0,1,0,0,1,'1,0,0,"R3");
        // R10: reset mid-read
        rst = 1'b1;
        step(0,1,0,1,1,'1,0,0,"R10");
        rst = 1'b0;
        step(1,1,1,1,1,'1,0,0,"R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule